// File: doc/BRIEF.md
# Echo Canceller Channel Mode Controller

This block holds the operating mode of every channel of a multi-channel echo canceller and decides, for each channel in turn, whether that channel adapts its filter, holds adaptation frozen while it keeps cancelling, or bypasses cancellation entirely. Channels are served in time-division order. An external scheduler presents one channel per service cycle, together with that channel's three detector flags: tone present, narrow-band signal present and instability present. One cycle later the block returns the control outputs that the signal path applies to that channel.

Each channel has a host-written configuration word with six fields. They select automatic bypass on a qualified disable tone, the tone rule set, whether the narrow-band flag is ignored, whether the DC-offset filters are turned off, whether ringing suppression is on, and whether tone-release interrupts are masked. A tone counts as qualified only after it has been present for a set number of consecutive frames. A channel leaves adaptation either by itself, when automatic bypass is set, or on a host mode write after the host has seen the sticky status bit. When a qualified tone goes away, the channel's release status is set and the active-low interrupt line is pulled down.

Two per-channel state machines drive the behaviour. The mode machine has states MODE_ADAPT and MODE_BYPASS. Its transitions are auto-bypass (MODE_ADAPT to MODE_BYPASS on a qualified tone with automatic bypass set) and host-set (either state to the state the host writes). The tone machine has states TQ_IDLE, TQ_COUNT and TQ_QUAL. Its transitions are start (TQ_IDLE to TQ_COUNT on the first tone frame), advance (TQ_COUNT to TQ_COUNT), qualify (TQ_IDLE or TQ_COUNT to TQ_QUAL when the run reaches the frame limit), hold (TQ_QUAL to TQ_QUAL), drop (TQ_COUNT to TQ_IDLE on a tone gap) and release (TQ_QUAL to TQ_IDLE on a tone gap).

Top module: `ecm_mode_ctrl`

## Requirements
- R1: After reset every channel is in MODE_ADAPT with all six configuration fields at 0. All status bits are clear and irq_n is 1.
- R2: A service cycle with svc_valid=1 yields, on the next cycle, out_valid=1 with out_ch equal to the served channel. out_adapt and out_bypass are never both 1.
- R3: A channel's tone-detect status is set once tone_in has been 1 on QUAL_FRAMES consecutive services of that channel. A service with tone_in=0 restarts the run.
- R4: When config bit 0 (automatic bypass) is 1, qualification moves the channel to MODE_BYPASS, shown as out_bypass=1 and out_adapt=0 on that same service's output. When the bit is 0, the mode is unchanged.
- R5: A tone_in=0 service of a qualified channel sets its release status. irq_n is 0 while any channel has release status set and config bit 5 (interrupt mask) at 0.
- R6: stat_rd returns {release, tone-detect} for stat_ch on stat_data[1:0] one cycle later and clears both bits. A status event in the same cycle as the read survives the clear.
- R7: A host mode write (mode_bypass 1 = MODE_BYPASS, 0 = MODE_ADAPT) takes effect at any time. It takes priority over an auto-bypass of the same channel in the same cycle.
- R8: With nb_in=1 and config bit 2 (narrow-band ignore) at 0, out_adapt is 0 while out_bypass stays 0. With bit 2 at 1, nb_in has no effect.
- R9: out_hpf_en is the inverse of config bit 3 (offset-filter disable).
- R10: out_suppress is 1 exactly when inst_in=1 and config bit 4 (ringing suppression enable) is 1.
- R11: out_std_sel follows config bit 1. The value 1 selects the phase-insensitive tone rule set.
- R12: Serving, configuring or switching one channel leaves the mode, configuration and tone run of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| svc_valid | input | 1 | A channel is served this cycle |
| svc_ch | input | CHW | Served channel index |
| tone_in | input | 1 | Disable tone present on served channel |
| nb_in | input | 1 | Narrow-band signal present on served channel |
| inst_in | input | 1 | Instability present on served channel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CHW | Channel of configuration write |
| cfg_wdata | input | 6 | Configuration word: 0 auto bypass, 1 rule set, 2 narrow-band ignore, 3 filter disable, 4 ring suppress, 5 irq mask |
| mode_we | input | 1 | Host mode write strobe |
| mode_ch | input | CHW | Channel of mode write |
| mode_bypass | input | 1 | 1 = bypass, 0 = enable adaptation |
| stat_rd | input | 1 | Status read strobe (clears on read) |
| stat_ch | input | CHW | Channel of status read |
| stat_data | output | 2 | Bit 1 release, bit 0 tone-detect |
| irq_n | output | 1 | Active-low interrupt |
| out_valid | output | 1 | Output controls valid |
| out_ch | output | CHW | Channel the outputs belong to |
| out_adapt | output | 1 | Filter adaptation enabled |
| out_bypass | output | 1 | Cancellation bypassed |
| out_hpf_en | output | 1 | Offset filters on both inputs enabled |
| out_suppress | output | 1 | Ringing suppression active |
| out_std_sel | output | 1 | Tone rule set select |

## Verification
The output path is swept over every combination of the narrow-band ignore, filter disable and ring enable bits against every pairing of nb_in and inst_in on each channel. This separates freezing from bypass and shows where a flag is ignored. Tone runs of every length from one frame to one past the limit, followed by a gap, show whether qualification lands exactly on QUAL_FRAMES and whether a release is raised only after a qualified run. A run broken one frame short shows whether the count restarts. A host write in the same cycle as a qualifying frame, a read that coincides with a qualifying frame, and a masked release each isolate one priority rule.

// File: rtl/ecm_pkg.sv
package ecm_pkg;

    typedef enum logic {
        MODE_ADAPT  = 1'b0,
        MODE_BYPASS = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        TQ_IDLE  = 2'd0,
        TQ_COUNT = 2'd1,
        TQ_QUAL  = 2'd2
    } tq_e;

    // Field order gives the host word layout, bit 5 down to bit 0.
    typedef struct packed {
        logic irq_mask;
        logic ring_en;
        logic hpf_dis;
        logic nb_ign;
        logic std_sel;
        logic auto_byp;
    } ch_cfg_t;

    localparam int CFG_W = $bits(ch_cfg_t);

endpackage

// File: rtl/ecm_cfg_store.sv
module ecm_cfg_store
    import ecm_pkg::*;
#(
    parameter int NCH = 128,
    parameter int CHW = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CHW-1:0]   cfg_ch,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [CHW-1:0]   svc_ch,
    output ch_cfg_t          svc_cfg,
    output logic [NCH-1:0]   mask_vec
);

    ch_cfg_t cfg_q [NCH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                cfg_q[i] <= '0;
            end
        end else if (cfg_we) begin
            cfg_q[cfg_ch] <= ch_cfg_t'(cfg_wdata);
        end
    end

    assign svc_cfg = cfg_q[svc_ch];

    for (genvar g = 0; g < NCH; g++) begin : g_mask
        assign mask_vec[g] = cfg_q[g].irq_mask;
    end

endmodule

// File: rtl/ecm_tone_qual.sv
module ecm_tone_qual
    import ecm_pkg::*;
#(
    parameter int NCH         = 128,
    parameter int QUAL_FRAMES = 3200,
    parameter int CHW         = $clog2(NCH),
    parameter int CW          = $clog2(QUAL_FRAMES + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           svc_valid,
    input  logic [CHW-1:0] svc_ch,
    input  logic           tone_in,
    output logic           qual_evt,
    output logic           rel_evt
);

    localparam logic [CW-1:0] QLIM = CW'(QUAL_FRAMES);

    tq_e           st_q  [NCH];
    logic [CW-1:0] cnt_q [NCH];

    tq_e           cur_st;
    logic [CW-1:0] cur_cnt;
    tq_e           nxt_st;
    logic [CW-1:0] nxt_cnt;
    logic [CW-1:0] inc_cnt;

    assign cur_st  = st_q[svc_ch];
    assign cur_cnt = cnt_q[svc_ch];
    assign inc_cnt = cur_cnt + CW'(1);

    // Next-state and event logic for the served channel
    always_comb begin
        nxt_st   = cur_st;
        nxt_cnt  = cur_cnt;
        qual_evt = 1'b0;
        rel_evt  = 1'b0;
        unique case (cur_st)
            TQ_IDLE, TQ_COUNT: begin
                if (tone_in) begin
                    if (inc_cnt >= QLIM) begin
                        nxt_st   = TQ_QUAL;
                        nxt_cnt  = QLIM;
                        qual_evt = svc_valid;
                    end else begin
                        nxt_st  = TQ_COUNT;
                        nxt_cnt = inc_cnt;
                    end
                end else begin
                    nxt_st  = TQ_IDLE;
                    nxt_cnt = '0;
                end
            end
            TQ_QUAL: begin
                if (!tone_in) begin
                    nxt_st  = TQ_IDLE;
                    nxt_cnt = '0;
                    rel_evt = svc_valid;
                end
            end
            default: begin
                nxt_st  = TQ_IDLE;
                nxt_cnt = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                st_q[i]  <= TQ_IDLE;
                cnt_q[i] <= '0;
            end
        end else if (svc_valid) begin
            st_q[svc_ch]  <= nxt_st;
            cnt_q[svc_ch] <= nxt_cnt;
        end
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> cur_cnt <= QLIM);

    // R3
    qual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_valid && cur_st == TQ_QUAL) |-> cur_cnt == QLIM);

    // R3
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_valid && cur_st == TQ_IDLE) |-> cur_cnt == '0);

endmodule

// File: rtl/ecm_mode_fsm.sv
module ecm_mode_fsm
    import ecm_pkg::*;
#(
    parameter int NCH = 128,
    parameter int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           svc_valid,
    input  logic [CHW-1:0] svc_ch,
    input  logic           auto_byp,
    input  logic           qual_evt,
    input  logic           mode_we,
    input  logic [CHW-1:0] mode_ch,
    input  logic           mode_bypass,
    output mode_e          mode_nxt
);

    mode_e mode_q [NCH];
    mode_e cur_mode;
    mode_e host_mode;
    logic  host_hit;

    assign cur_mode  = mode_q[svc_ch];
    assign host_mode = mode_bypass ? MODE_BYPASS : MODE_ADAPT;
    assign host_hit  = mode_we && (mode_ch == svc_ch);

    // Transition logic for the served channel; host-set wins
    always_comb begin
        mode_nxt = cur_mode;
        unique case (cur_mode)
            MODE_ADAPT: begin
                if (svc_valid && auto_byp && qual_evt) begin
                    mode_nxt = MODE_BYPASS;
                end
            end
            MODE_BYPASS: begin
                mode_nxt = MODE_BYPASS;
            end
            default: mode_nxt = MODE_ADAPT;
        endcase
        if (host_hit) begin
            mode_nxt = host_mode;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                mode_q[i] <= MODE_ADAPT;
            end
        end else begin
            if (svc_valid) begin
                mode_q[svc_ch] <= mode_nxt;
            end
            if (mode_we && !(svc_valid && host_hit)) begin
                mode_q[mode_ch] <= host_mode;
            end
        end
    end

    // R7
    host_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && !svc_valid) |=> mode_q[$past(mode_ch)] == $past(host_mode));

endmodule

// File: rtl/ecm_status.sv
module ecm_status #(
    parameter int NCH = 128,
    parameter int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           svc_valid,
    input  logic [CHW-1:0] svc_ch,
    input  logic           qual_evt,
    input  logic           rel_evt,
    input  logic           stat_rd,
    input  logic [CHW-1:0] stat_ch,
    input  logic [NCH-1:0] mask_vec,
    output logic [1:0]     stat_data,
    output logic           irq_n
);

    logic [NCH-1:0] td_q;
    logic [NCH-1:0] rel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            td_q      <= '0;
            rel_q     <= '0;
            stat_data <= '0;
        end else begin
            if (stat_rd) begin
                stat_data      <= {rel_q[stat_ch], td_q[stat_ch]};
                td_q[stat_ch]  <= 1'b0;
                rel_q[stat_ch] <= 1'b0;
            end
            if (svc_valid && qual_evt) begin
                td_q[svc_ch] <= 1'b1;
            end
            if (svc_valid && rel_evt) begin
                rel_q[svc_ch] <= 1'b1;
            end
        end
    end

    assign irq_n = ~|(rel_q & ~mask_vec);

    // R5
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_valid && rel_evt && !mask_vec[svc_ch]) |=> !irq_n);

    // R6
    evt_survive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_valid && qual_evt && stat_rd && stat_ch == svc_ch) |=> td_q[$past(svc_ch)]);

endmodule

// File: rtl/ecm_mode_ctrl.sv
module ecm_mode_ctrl
    import ecm_pkg::*;
#(
    parameter int NCH         = 128,
    parameter int QUAL_FRAMES = 3200,
    parameter int CHW         = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             svc_valid,
    input  logic [CHW-1:0]   svc_ch,
    input  logic             tone_in,
    input  logic             nb_in,
    input  logic             inst_in,
    input  logic             cfg_we,
    input  logic [CHW-1:0]   cfg_ch,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             mode_we,
    input  logic [CHW-1:0]   mode_ch,
    input  logic             mode_bypass,
    input  logic             stat_rd,
    input  logic [CHW-1:0]   stat_ch,
    output logic [1:0]       stat_data,
    output logic             irq_n,
    output logic             out_valid,
    output logic [CHW-1:0]   out_ch,
    output logic             out_adapt,
    output logic             out_bypass,
    output logic             out_hpf_en,
    output logic             out_suppress,
    output logic             out_std_sel
);

    ch_cfg_t        svc_cfg;
    logic [NCH-1:0] mask_vec;
    logic           qual_evt;
    logic           rel_evt;
    mode_e          mode_nxt;
    logic           nb_freeze;

    ecm_cfg_store #(.NCH(NCH), .CHW(CHW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_ch    (cfg_ch),
        .cfg_wdata (cfg_wdata),
        .svc_ch    (svc_ch),
        .svc_cfg   (svc_cfg),
        .mask_vec  (mask_vec)
    );

    ecm_tone_qual #(.NCH(NCH), .QUAL_FRAMES(QUAL_FRAMES), .CHW(CHW)) u_tq (
        .clk       (clk),
        .rst_n     (rst_n),
        .svc_valid (svc_valid),
        .svc_ch    (svc_ch),
        .tone_in   (tone_in),
        .qual_evt  (qual_evt),
        .rel_evt   (rel_evt)
    );

    ecm_mode_fsm #(.NCH(NCH), .CHW(CHW)) u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .svc_valid   (svc_valid),
        .svc_ch      (svc_ch),
        .auto_byp    (svc_cfg.auto_byp),
        .qual_evt    (qual_evt),
        .mode_we     (mode_we),
        .mode_ch     (mode_ch),
        .mode_bypass (mode_bypass),
        .mode_nxt    (mode_nxt)
    );

    ecm_status #(.NCH(NCH), .CHW(CHW)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .svc_valid (svc_valid),
        .svc_ch    (svc_ch),
        .qual_evt  (qual_evt),
        .rel_evt   (rel_evt),
        .stat_rd   (stat_rd),
        .stat_ch   (stat_ch),
        .mask_vec  (mask_vec),
        .stat_data (stat_data),
        .irq_n     (irq_n)
    );

    assign nb_freeze = nb_in && !svc_cfg.nb_ign;

    // Output process: controls for the served channel, one cycle later
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_ch       <= '0;
            out_adapt    <= 1'b0;
            out_bypass   <= 1'b0;
            out_hpf_en   <= 1'b0;
            out_suppress <= 1'b0;
            out_std_sel  <= 1'b0;
        end else begin
            out_valid <= svc_valid;
            if (svc_valid) begin
                out_ch       <= svc_ch;
                out_adapt    <= (mode_nxt == MODE_ADAPT) && !nb_freeze;
                out_bypass   <= (mode_nxt == MODE_BYPASS);
                out_hpf_en   <= !svc_cfg.hpf_dis;
                out_suppress <= svc_cfg.ring_en && inst_in;
                out_std_sel  <= svc_cfg.std_sel;
            end
        end
    end

    // R2
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_adapt && out_bypass));

    // R2
    echo_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |=> (out_valid && out_ch == $past(svc_ch)));

    // R7
    host_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_valid && mode_we && mode_ch == svc_ch) |=> out_bypass == $past(mode_bypass));

    // R8
    nb_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_valid && nb_in && !svc_cfg.nb_ign) |=> !out_adapt);

    // R10
    ring_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_valid && !svc_cfg.ring_en) |=> !out_suppress);

    // R9
    hpf_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_valid && svc_cfg.hpf_dis) |=> !out_hpf_en);

endmodule

// File: tb/sim_ecm_mode_ctrl.sv
module sim_ecm_mode_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam int Q          = 4;
    localparam int CHW        = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           svc_valid = 1'b0;
    logic [CHW-1:0] svc_ch = '0;
    logic           tone_in = 1'b0;
    logic           nb_in = 1'b0;
    logic           inst_in = 1'b0;
    logic           cfg_we = 1'b0;
    logic [CHW-1:0] cfg_ch = '0;
    logic [5:0]     cfg_wdata = '0;
    logic           mode_we = 1'b0;
    logic [CHW-1:0] mode_ch = '0;
    logic           mode_bypass = 1'b0;
    logic           stat_rd = 1'b0;
    logic [CHW-1:0] stat_ch = '0;
    logic [1:0]     stat_data;
    logic           irq_n;
    logic           out_valid;
    logic [CHW-1:0] out_ch;
    logic           out_adapt;
    logic           out_bypass;
    logic           out_hpf_en;
    logic           out_suppress;
    logic           out_std_sel;

    int n_checks = 0;
    int n_errors = 0;

    ecm_mode_ctrl #(.NCH(NCH), .QUAL_FRAMES(Q), .CHW(CHW)) u0 (
        .clk(clk), .rst_n(rst_n), .svc_valid(svc_valid), .svc_ch(svc_ch),
        .tone_in(tone_in), .nb_in(nb_in), .inst_in(inst_in),
        .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_wdata(cfg_wdata),
        .mode_we(mode_we), .mode_ch(mode_ch), .mode_bypass(mode_bypass),
        .stat_rd(stat_rd), .stat_ch(stat_ch), .stat_data(stat_data),
        .irq_n(irq_n), .out_valid(out_valid), .out_ch(out_ch),
        .out_adapt(out_adapt), .out_bypass(out_bypass), .out_hpf_en(out_hpf_en),
        .out_suppress(out_suppress), .out_std_sel(out_std_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int ch, input int w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = CHW'(ch); cfg_wdata = 6'(w);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_mode(input int ch, input bit byp);
        @(negedge clk);
        mode_we = 1'b1; mode_ch = CHW'(ch); mode_bypass = byp;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    // One service cycle; outputs sampled at the following falling edge
    task automatic serve(input int ch, input bit t, input bit nb, input bit inst);
        @(negedge clk);
        svc_valid = 1'b1; svc_ch = CHW'(ch); tone_in = t; nb_in = nb; inst_in = inst;
        @(negedge clk);
        svc_valid = 1'b0; tone_in = 1'b0; nb_in = 1'b0; inst_in = 1'b0;
    endtask

    task automatic read_stat(input int ch, output int val);
        @(negedge clk);
        stat_rd = 1'b1; stat_ch = CHW'(ch);
        @(negedge clk);
        stat_rd = 1'b0;
        val = int'(stat_data);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int sv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state on every channel
        check("R1 irq_n", int'(irq_n), 1);
        for (int c = 0; c < NCH; c++) begin
            serve(c, 0, 0, 0);
            check("R2 out_valid", int'(out_valid), 1);
            check("R2 out_ch", int'(out_ch), c);
            check("R1 adapt", int'(out_adapt), 1);
            check("R1 bypass", int'(out_bypass), 0);
            check("R1 hpf_en", int'(out_hpf_en), 1);
            check("R1 std_sel", int'(out_std_sel), 0);
            read_stat(c, sv);
            check("R1 status", sv, 0);
        end

        // R8 R9 R10 R11 sweep: cfg bits 1..4 against nb/inst flags
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < 16; k++) begin
                int w;
                w = k << 1;
                write_cfg(c, w);
                for (int f = 0; f < 4; f++) begin
                    bit nb, inst, nbi, hd, re, ss;
                    nb = f[0]; inst = f[1];
                    ss = k[0]; nbi = k[1]; hd = k[2]; re = k[3];
                    serve(c, 0, nb, inst);
                    check("R8 adapt", int'(out_adapt), int'(!(nb && !nbi)));
                    check("R8 bypass", int'(out_bypass), 0);
                    check("R9 hpf_en", int'(out_hpf_en), int'(!hd));
                    check("R10 suppress", int'(out_suppress), int'(re && inst));
                    check("R11 std_sel", int'(out_std_sel), int'(ss));
                end
            end
            write_cfg(c, 0);
        end

        // R3 R4 R5: run lengths 1..Q+1 on channel 1, auto off
        for (int len = 1; len <= Q + 1; len++) begin
            bit qd;
            qd = (len >= Q);
            for (int i = 0; i < len; i++) serve(1, 1, 0, 0);
            check("R4 manual adapt", int'(out_adapt), 1);
            read_stat(1, sv);
            check("R3 td after run", sv, int'(qd));
            serve(1, 0, 0, 0);
            check("R5 irq_n after gap", int'(irq_n), int'(!qd));
            read_stat(1, sv);
            check("R5 release status", sv, qd ? 2 : 0);
            check("R6 irq_n after read", int'(irq_n), 1);
        end

        // R3: broken run restarts count
        for (int i = 0; i < Q - 1; i++) serve(1, 1, 0, 0);
        serve(1, 0, 0, 0);
        for (int i = 0; i < Q - 1; i++) serve(1, 1, 0, 0);
        read_stat(1, sv);
        check("R3 broken run", sv, 0);
        serve(1, 0, 0, 0);

        // R4 R12: auto bypass on channel 2, channel 3 untouched
        write_cfg(2, 1);
        for (int i = 0; i < Q - 1; i++) begin
            serve(2, 1, 0, 0);
            check("R4 before qual", int'(out_bypass), 0);
        end
        serve(2, 1, 0, 0);
        check("R4 auto bypass", int'(out_bypass), 1);
        check("R4 auto adapt", int'(out_adapt), 0);
        serve(3, 0, 0, 0);
        check("R12 other channel", int'(out_adapt), 1);
        serve(2, 0, 0, 0);
        check("R4 bypass kept", int'(out_bypass), 1);
        write_mode(2, 0);
        serve(2, 0, 0, 0);
        check("R7 host adapt", int'(out_adapt), 1);
        read_stat(2, sv);
        check("R5 status ch2", sv, 3);

        // R7: host write in the qualifying cycle wins
        for (int i = 0; i < Q - 1; i++) serve(2, 1, 0, 0);
        @(negedge clk);
        svc_valid = 1'b1; svc_ch = 2'd2; tone_in = 1'b1;
        mode_we = 1'b1; mode_ch = 2'd2; mode_bypass = 1'b0;
        @(negedge clk);
        svc_valid = 1'b0; tone_in = 1'b0; mode_we = 1'b0;
        check("R7 priority adapt", int'(out_adapt), 1);
        check("R7 priority bypass", int'(out_bypass), 0);
        serve(2, 1, 0, 0);
        check("R7 stays adapt", int'(out_adapt), 1);
        serve(2, 0, 0, 0);
        read_stat(2, sv);
        check("R3 td ch2", sv, 3);

        // R7 R8: host bypass, nb has no effect on bypass
        write_mode(0, 1);
        serve(0, 0, 1, 0);
        check("R7 host bypass", int'(out_bypass), 1);
        check("R8 bypass adapt", int'(out_adapt), 0);
        serve(1, 0, 0, 0);
        check("R12 ch1 mode", int'(out_adapt), 1);
        write_mode(0, 0);

        // R5: masked release leaves irq_n high
        write_cfg(1, 32);
        for (int i = 0; i < Q; i++) serve(1, 1, 0, 0);
        serve(1, 0, 0, 0);
        check("R5 masked irq", int'(irq_n), 1);
        read_stat(1, sv);
        check("R5 masked status", sv, 3);
        write_cfg(1, 0);

        // R6: read in the same cycle as a qualifying frame
        for (int i = 0; i < Q - 1; i++) serve(1, 1, 0, 0);
        @(negedge clk);
        svc_valid = 1'b1; svc_ch = 2'd1; tone_in = 1'b1;
        stat_rd = 1'b1; stat_ch = 2'd1;
        @(negedge clk);
        svc_valid = 1'b0; tone_in = 1'b0; stat_rd = 1'b0;
        check("R6 old value", int'(stat_data), 0);
        read_stat(1, sv);
        check("R6 event survives", sv, 1);
        read_stat(1, sv);
        check("R6 cleared", sv, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule